// File: doc/BRIEF.md
# Serial Sector Protection Register

This block models the per-sector protection register of a serial flash device, reached through a mode-0 SPI slave port. The host lowers chip select and sends a four-byte program command. It then sends one protection byte per sector. Those bytes land in a staging buffer. When chip select rises, the staged bytes are committed into the protection register, and a self-timed programming window starts. During that window, status bit 7 reads as busy. A four-byte read command streams the register back to the host, and a one-byte status command returns the ready/busy byte.

The serial pins are taken into the system clock domain through two-flop synchronisers. Their edges are then detected in that domain, so SCK must run well below the system clock. Each sector also drives a pair of outputs, `sect_locked` and `sect_unknown`, which a neighbouring array controller can use to gate writes.

The command state machine has the following states:
- `ST_IDLE` waits for the opcode byte.
- `ST_HDR_PROG` and `ST_HDR_READ` match the three trailing header bytes.
- `ST_PROG_DATA` stages protection bytes.
- `ST_READ_DATA` streams register bytes.
- `ST_STATUS` repeats the status byte.
- `ST_DISCARD` swallows the rest of a rejected frame.

The transitions are as follows:
- From `ST_IDLE`, the status opcode leads to `ST_STATUS`.
- From `ST_IDLE`, any other opcode received while busy leads to `ST_DISCARD`.
- From `ST_IDLE`, the first program byte leads to `ST_HDR_PROG`, and the first read byte leads to `ST_HDR_READ`.
- From `ST_IDLE`, an unknown opcode leads to `ST_DISCARD`.
- A header byte that does not match leads to `ST_DISCARD`.
- The third matching header byte leads to `ST_PROG_DATA` or `ST_READ_DATA`.
- Any state returns to `ST_IDLE` when chip select goes high.

Top module: `sect_guard_top`

## Requirements
- R1: After a program command with the header 0x3D 0x2A 0x7F 0xFC, data bytes shifted MSB first are assigned to sectors in ascending order, the first to sector 0.
- R2: A data byte beyond SECTORS bytes wraps: byte number SECTORS+k is written into sector k, replacing the earlier byte.
- R3: A committed byte 0x00 gives `sect_locked`=0 and `sect_unknown`=0 for that sector. A committed byte 0xFF gives `sect_locked`=1 and `sect_unknown`=0.
- R4: Any other committed value is stored and read back unchanged, and sets `sect_unknown`=1 and `sect_locked`=1 for that sector.
- R5: A sector that received no byte in a committed command keeps its stored byte and gets `sect_unknown`=1 and `sect_locked`=1. This includes a command with a full header and no data bytes.
- R6: Only the rising edge of chip select commits, and only after a complete, matching program header. A frame with a wrong header byte, an aborted header or an unknown opcode changes nothing and starts no busy window.
- R7: The status opcode 0xD7 returns 0x00 while busy and 0x80 when ready, repeated for every further byte in the frame. Busy lasts exactly PROG_CYCLES clock cycles, starting on the cycle after the commit.
- R8: While busy, any command other than a status read is ignored, and a program command sent then leaves the register unchanged.
- R9: The read command 0x32 0x00 0x00 0x00 streams register bytes MSB first, starting at sector 0 and wrapping after the last sector.
- R10: Each program command discards previously staged bytes. Only bytes sent in the current command count as written.
- R11: After reset every register byte is 0xFF, every sector is locked and not unknown, and status reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block, 0 while deselected |
| sect_locked | output | SECTORS | Per-sector write lock |
| sect_unknown | output | SECTORS | Per-sector undefined-status flag |

## Verification
The bench builds the block with four sectors and a 500-cycle programming window. Four sectors make it feasible to sweep every combination of unprotect code, protect code and undefined code across all sectors. The 500-cycle window is long enough for a status read and a rejected program frame to fall inside it. With only four sectors, a six-byte program frame and an eight-byte read reach the wrap boundary on both paths. Short frames, header-only frames and corrupted headers are then run against an arithmetic model of the register held in the bench.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_PROG,
        ST_HDR_READ,
        ST_PROG_DATA,
        ST_READ_DATA,
        ST_STATUS,
        ST_DISCARD
    } sgp_state_e;

    localparam logic [BYTE_W-1:0] CODE_OPEN  = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_GUARD = 8'hFF;

endpackage

// File: rtl/sgp_spi_front.sv
module sgp_spi_front
    import sgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_load,
    output logic              sel,
    output logic              cs_rise,
    output logic              miso
);

    localparam int BCW = $clog2(BYTE_W);

    logic cs_s1, cs_s2, cs_s3;
    logic ck_s1, ck_s2, ck_s3;
    logic mo_s1, mo_s2;
    logic sck_rise, sck_fall;

    logic [BCW-1:0]    bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              load_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s1 <= 1'b1;
            cs_s2 <= 1'b1;
            cs_s3 <= 1'b1;
            ck_s1 <= 1'b0;
            ck_s2 <= 1'b0;
            ck_s3 <= 1'b0;
            mo_s1 <= 1'b0;
            mo_s2 <= 1'b0;
        end else begin
            cs_s1 <= cs_n;
            cs_s2 <= cs_s1;
            cs_s3 <= cs_s2;
            ck_s1 <= sck;
            ck_s2 <= ck_s1;
            ck_s3 <= ck_s2;
            mo_s1 <= mosi;
            mo_s2 <= mo_s1;
        end
    end

    assign sel      = ~cs_s2;
    assign cs_rise  = cs_s2 & ~cs_s3;
    assign sck_rise = sel & ck_s2 & ~ck_s3;
    assign sck_fall = sel & ~ck_s2 & ck_s3;
    assign tx_load  = sck_fall & load_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            load_pend <= 1'b0;
            tx_sh     <= '0;
        end else if (!sel) begin
            bit_cnt   <= '0;
            rx_valid  <= 1'b0;
            load_pend <= 1'b0;
            tx_sh     <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-3:0], mo_s2};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BCW'(BYTE_W-1)) begin
                    rx_byte   <= {rx_sh, mo_s2};
                    rx_valid  <= 1'b1;
                    load_pend <= 1'b1;
                end
            end
            if (sck_fall) begin
                if (load_pend) begin
                    tx_sh     <= tx_byte;
                    load_pend <= 1'b0;
                end else begin
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = sel & tx_sh[BYTE_W-1];

endmodule

// File: rtl/sgp_cmd_fsm.sv
module sgp_cmd_fsm
    import sgp_pkg::*;
#(
    parameter int          SECTORS = 8,
    parameter logic [31:0] PROG_OP = 32'h3D2A7FFC,
    parameter logic [31:0] READ_OP = 32'h32000000,
    parameter logic [7:0]  STAT_OP = 8'hD7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel,
    input  logic                       cs_rise,
    input  logic                       rx_valid,
    input  logic [BYTE_W-1:0]          rx_byte,
    input  logic                       tx_load,
    input  logic                       busy,
    input  logic [BYTE_W-1:0]          rd_byte,
    output logic [BYTE_W-1:0]          tx_byte,
    output logic [$clog2(SECTORS)-1:0] rd_idx,
    output logic [$clog2(SECTORS)-1:0] wr_idx,
    output logic                       stage_start,
    output logic                       stage_we,
    output logic                       commit
);

    localparam int IDXW = $clog2(SECTORS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(SECTORS - 1);

    sgp_state_e        state, nxt;
    logic [1:0]        hdr_cnt;
    logic [BYTE_W-1:0] hdr_exp;
    logic              hdr_ok, hdr_last, in_hdr;

    function automatic logic [BYTE_W-1:0] hdr_byte(input logic [31:0] op,
                                                   input logic [1:0]  n);
        unique case (n)
            2'd0:    return op[23:16];
            2'd1:    return op[15:8];
            default: return op[7:0];
        endcase
    endfunction

    assign in_hdr   = (state == ST_HDR_PROG) || (state == ST_HDR_READ);
    assign hdr_exp  = (state == ST_HDR_READ) ? hdr_byte(READ_OP, hdr_cnt)
                                             : hdr_byte(PROG_OP, hdr_cnt);
    assign hdr_ok   = (rx_byte == hdr_exp);
    assign hdr_last = (hdr_cnt == 2'd2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!sel) begin
            nxt = ST_IDLE;
        end else if (rx_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_byte == STAT_OP)               nxt = ST_STATUS;
                    else if (busy)                        nxt = ST_DISCARD;
                    else if (rx_byte == PROG_OP[31:24])   nxt = ST_HDR_PROG;
                    else if (rx_byte == READ_OP[31:24])   nxt = ST_HDR_READ;
                    else                                  nxt = ST_DISCARD;
                end
                ST_HDR_PROG: begin
                    if (!hdr_ok)       nxt = ST_DISCARD;
                    else if (hdr_last) nxt = ST_PROG_DATA;
                end
                ST_HDR_READ: begin
                    if (!hdr_ok)       nxt = ST_DISCARD;
                    else if (hdr_last) nxt = ST_READ_DATA;
                end
                ST_PROG_DATA, ST_READ_DATA, ST_STATUS, ST_DISCARD: nxt = state;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // header and index counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_cnt <= '0;
            wr_idx  <= '0;
            rd_idx  <= '0;
        end else begin
            if (state != nxt)            hdr_cnt <= '0;
            else if (rx_valid && in_hdr) hdr_cnt <= hdr_cnt + 1'b1;

            if (stage_start)   wr_idx <= '0;
            else if (stage_we) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;

            if (state != ST_READ_DATA) rd_idx <= '0;
            else if (tx_load)          rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        stage_start = sel && rx_valid && (state == ST_HDR_PROG) && hdr_ok && hdr_last;
        stage_we    = sel && rx_valid && (state == ST_PROG_DATA);
        commit      = cs_rise && (state == ST_PROG_DATA);
        unique case (state)
            ST_STATUS:    tx_byte = {~busy, {(BYTE_W-1){1'b0}}};
            ST_READ_DATA: tx_byte = rd_byte;
            default:      tx_byte = '0;
        endcase
    end

endmodule

// File: rtl/sgp_prot_store.sv
module sgp_prot_store
    import sgp_pkg::*;
#(
    parameter int SECTORS     = 8,
    parameter int PROG_CYCLES = 250000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stage_start,
    input  logic                       stage_we,
    input  logic [$clog2(SECTORS)-1:0] wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       commit,
    input  logic [$clog2(SECTORS)-1:0] rd_idx,
    output logic [BYTE_W-1:0]          rd_byte,
    output logic                       busy,
    output logic [SECTORS-1:0]         locked,
    output logic [SECTORS-1:0]         unknown
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [BYTE_W-1:0] stage_q [SECTORS];
    logic [SECTORS-1:0] written_q;
    logic [BYTE_W-1:0] prot_q  [SECTORS];
    logic [SECTORS-1:0] unk_q;
    logic [CW-1:0]      timer_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written_q <= '0;
            for (int i = 0; i < SECTORS; i++) stage_q[i] <= '0;
        end else if (stage_start) begin
            written_q <= '0;
        end else if (stage_we) begin
            stage_q[wr_idx]   <= wr_data;
            written_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unk_q <= '0;
            for (int i = 0; i < SECTORS; i++) prot_q[i] <= CODE_GUARD;
        end else if (commit) begin
            for (int i = 0; i < SECTORS; i++) begin
                if (written_q[i]) begin
                    prot_q[i] <= stage_q[i];
                    unk_q[i]  <= (stage_q[i] != CODE_OPEN) && (stage_q[i] != CODE_GUARD);
                end else begin
                    unk_q[i]  <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             timer_q <= '0;
        else if (commit)        timer_q <= CW'(PROG_CYCLES);
        else if (timer_q != '0) timer_q <= timer_q - 1'b1;
    end

    assign busy    = (timer_q != '0);
    assign rd_byte = prot_q[rd_idx];

    for (genvar g = 0; g < SECTORS; g++) begin : g_sect
        assign unknown[g] = unk_q[g];
        assign locked[g]  = unk_q[g] | (prot_q[g] != CODE_OPEN);
    end

endmodule

// File: rtl/sect_guard_top.sv
module sect_guard_top
    import sgp_pkg::*;
#(
    parameter int          SECTORS     = 8,
    parameter int          PROG_CYCLES = 250000,
    parameter logic [31:0] PROG_OP     = 32'h3D2A7FFC,
    parameter logic [31:0] READ_OP     = 32'h32000000,
    parameter logic [7:0]  STAT_OP     = 8'hD7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               mosi,
    output logic               miso,
    output logic [SECTORS-1:0] sect_locked,
    output logic [SECTORS-1:0] sect_unknown
);

    localparam int IDXW = $clog2(SECTORS);

    logic [BYTE_W-1:0] rx_byte, tx_byte, rd_byte;
    logic              rx_valid, tx_load, sel, cs_rise;
    logic              busy, commit, stage_start, stage_we;
    logic [IDXW-1:0]   rd_idx, wr_idx;

    sgp_spi_front front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .tx_load  (tx_load),
        .sel      (sel),
        .cs_rise  (cs_rise),
        .miso     (miso)
    );

    sgp_cmd_fsm #(
        .SECTORS (SECTORS),
        .PROG_OP (PROG_OP),
        .READ_OP (READ_OP),
        .STAT_OP (STAT_OP)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .cs_rise     (cs_rise),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_load     (tx_load),
        .busy        (busy),
        .rd_byte     (rd_byte),
        .tx_byte     (tx_byte),
        .rd_idx      (rd_idx),
        .wr_idx      (wr_idx),
        .stage_start (stage_start),
        .stage_we    (stage_we),
        .commit      (commit)
    );

    sgp_prot_store #(
        .SECTORS     (SECTORS),
        .PROG_CYCLES (PROG_CYCLES)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_start (stage_start),
        .stage_we    (stage_we),
        .wr_idx      (wr_idx),
        .wr_data     (rx_byte),
        .commit      (commit),
        .rd_idx      (rd_idx),
        .rd_byte     (rd_byte),
        .busy        (busy),
        .locked      (sect_locked),
        .unknown     (sect_unknown)
    );

endmodule

// File: rtl/sgp_checker.sv
module sgp_checker #(
    parameter int SECTORS     = 8,
    parameter int PROG_CYCLES = 250000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               commit,
    input logic               busy,
    input logic [SECTORS-1:0] sect_locked,
    input logic [SECTORS-1:0] sect_unknown
);

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= '0;
        else if (!busy) run_q <= '0;
        else            run_q <= run_q + 1'b1;
    end

    // R7: a commit opens the busy window on the next cycle
    a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R7: the busy window is exactly PROG_CYCLES long
    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(PROG_CYCLES)));

    // R7: the window never outlasts PROG_CYCLES
    a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 32'(PROG_CYCLES)));

    // R8: no commit while programming is in progress
    a_r8_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit);

    // R6: protection outputs move only after a commit
    a_r6_stable_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(sect_locked) && $stable(sect_unknown)));

    // R4: an unknown sector is always locked
    a_r4_unknown_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ((sect_unknown & ~sect_locked) == '0));

endmodule

bind sect_guard_top sgp_checker #(
    .SECTORS     (SECTORS),
    .PROG_CYCLES (PROG_CYCLES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (commit),
    .busy         (busy),
    .sect_locked  (sect_locked),
    .sect_unknown (sect_unknown)
);

// File: tb/sect_guard_top_tb_top.sv
module sect_guard_top_tb_top;

    localparam int S    = 4;
    localparam int PC   = 500;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    logic [S-1:0] sect_locked, sect_unknown;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    logic [7:0] pdat  [16];
    logic [7:0] e_reg [S];
    logic       e_unk [S];
    logic [7:0] rb;

    always #5 clk = ~clk;

    sect_guard_top #(.SECTORS(S), .PROG_CYCLES(PC)) dut_i (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .mosi (mosi),
        .miso (miso), .sect_locked (sect_locked), .sect_unknown (sect_unknown)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            waitc(HALF);
            rx[b] = miso;
            sck = 1'b1;
            waitc(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic cs_hi();
        waitc(HALF);
        cs_n = 1'b1;
        waitc(8);
    endtask

    task automatic send_prog(input int cnt);
        logic [7:0] r;
        cs_lo();
        xfer(8'h3D, r); xfer(8'h2A, r); xfer(8'h7F, r); xfer(8'hFC, r);
        for (int k = 0; k < cnt; k++) xfer(pdat[k], r);
        cs_hi();
    endtask

    // bench model of a committed program frame
    task automatic model_prog(input int cnt);
        logic wr [S];
        for (int i = 0; i < S; i++) wr[i] = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            e_reg[k % S] = pdat[k];
            wr[k % S] = 1'b1;
        end
        for (int i = 0; i < S; i++)
            e_unk[i] = wr[i] ? !(e_reg[i] == 8'h00 || e_reg[i] == 8'hFF) : 1'b1;
    endtask

    task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
        logic [7:0] r;
        cs_lo();
        xfer(8'hD7, r);
        xfer(8'h00, s0);
        xfer(8'h00, s1);
        cs_hi();
    endtask

    task automatic check_state(input string req, input int nbytes);
        logic [7:0] r;
        cs_lo();
        xfer(8'h32, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
        for (int k = 0; k < nbytes; k++) begin
            xfer(8'h00, r);
            chk(r == e_reg[k % S], req, r, e_reg[k % S]);
        end
        cs_hi();
        for (int i = 0; i < S; i++) begin
            logic el;
            el = e_unk[i] || (e_reg[i] != 8'h00);
            chk(sect_locked[i] == el, {req, " locked"}, sect_locked[i], el);
            chk(sect_unknown[i] == e_unk[i], {req, " unknown"}, sect_unknown[i], e_unk[i]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] s0, s1, r;
        for (int i = 0; i < S; i++) begin e_reg[i] = 8'hFF; e_unk[i] = 1'b0; end
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R11: reset state
        chk(sect_locked == '1, "R11 locked", sect_locked, 4'hF);
        chk(sect_unknown == '0, "R11 unknown", sect_unknown, 0);
        chk(miso == 1'b0, "R11 miso", miso, 0);
        read_status(s0, s1);
        chk(s0 == 8'h80, "R11 status", s0, 8'h80);
        check_state("R11", S);

        // R7 / R8: busy window and rejection of a program while busy
        pdat[0] = 8'h00; pdat[1] = 8'hFF; pdat[2] = 8'h00; pdat[3] = 8'hFF;
        send_prog(4);
        model_prog(4);
        pdat[0] = 8'h5A;
        send_prog(1);
        read_status(s0, s1);
        chk(s0 == 8'h00, "R7 busy", s0, 8'h00);
        waitc(PC + 20);
        read_status(s0, s1);
        chk(s0 == 8'h80, "R7 ready", s0, 8'h80);
        chk(s1 == 8'h80, "R7 repeat", s1, 8'h80);
        check_state("R8", S);

        // R1 R3 R4: sweep all code combinations over every sector
        for (int n = 0; n < 81; n++) begin
            int v;
            v = n;
            for (int i = 0; i < S; i++) begin
                int d;
                d = v % 3;
                v = v / 3;
                pdat[i] = (d == 0) ? 8'h00 : (d == 1) ? 8'hFF : 8'(8'h20 + n + i);
            end
            send_prog(S);
            model_prog(S);
            waitc(PC + 10);
            check_state("R1/R3/R4 sweep", S);
        end

        // R2: wrap on the write side
        pdat[0] = 8'h00; pdat[1] = 8'h00; pdat[2] = 8'h00; pdat[3] = 8'h00;
        pdat[4] = 8'hFF; pdat[5] = 8'h5A;
        send_prog(6);
        model_prog(6);
        waitc(PC + 10);
        check_state("R2", S);

        // R9: read wraps after the last sector
        check_state("R9", 2 * S);

        // R5: short frame leaves unwritten sectors unknown with old bytes
        pdat[0] = 8'h00; pdat[1] = 8'hFF;
        send_prog(2);
        model_prog(2);
        waitc(PC + 10);
        check_state("R5", S);

        // R10: staged bytes of a prior command are not reused
        pdat[0] = 8'h00; pdat[1] = 8'h00; pdat[2] = 8'h00; pdat[3] = 8'h00;
        send_prog(4);
        model_prog(4);
        waitc(PC + 10);
        pdat[0] = 8'hFF;
        send_prog(1);
        model_prog(1);
        waitc(PC + 10);
        check_state("R10", S);

        // R6: corrupted header, aborted header and unknown opcode
        cs_lo();
        xfer(8'h3D, r); xfer(8'h2A, r); xfer(8'h00, r); xfer(8'hFC, r);
        for (int k = 0; k < S; k++) xfer(8'h00, r);
        cs_hi();
        read_status(s0, s1);
        chk(s0 == 8'h80, "R6 bad header no busy", s0, 8'h80);
        cs_lo();
        xfer(8'h3D, r); xfer(8'h2A, r);
        cs_hi();
        cs_lo();
        xfer(8'h9F, r); xfer(8'h00, r);
        cs_hi();
        read_status(s0, s1);
        chk(s0 == 8'h80, "R6 abort no busy", s0, 8'h80);
        check_state("R6", S);

        // R5: full header with no data bytes
        send_prog(0);
        model_prog(0);
        waitc(PC + 10);
        check_state("R5 empty", S);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule